// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns a single access request into the sequence of column addresses for a memory burst. A one-cycle start strobe carries a 9-bit starting column, and the block then presents one column address per clock until the configured number of beats has been issued. The burst length and the ordering rule are taken from the mode configuration and held for the whole burst.

Every burst stays inside an aligned block of columns whose size equals the burst length. The upper column bits name that block and never change during a burst. The lower bits walk through the block, starting at the requested offset, either by counting upward with wraparound or by XOR-ing the offset with the beat number. A valid flag marks each beat, and a last flag marks the final one. A strobe that arrives while a burst is still running drops the rest of that burst, and the new burst starts on the next cycle.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is asserted (rst_n low) and after its release with no strobe, valid_o and last_o are 0.
- R2: A start_i sampled high at a rising edge makes the following cycle carry beat 0 with valid_o = 1 and col_o equal to the sampled start_col_i.
- R3: bl_code_i is sampled with the strobe and gives the beat count: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. The reserved codes 4 to 7 give 1. Exactly that many beats follow on consecutive cycles, each with valid_o = 1.
- R4: During a burst of length L = 2^k, col_o bits 8..k equal those of the start column for every beat. The burst wraps inside its aligned block and never moves into the next one.
- R5: With btype_i = 0 (sequential), bits k-1..0 of beat n equal (start offset + n) mod L.
- R6: With btype_i = 1 (interleaved), bits k-1..0 of beat n equal the start offset XOR n.
- R7: last_o is 1 on the final beat of a burst and 0 on every other cycle. A length-1 burst is a single beat with last_o = 1.
- R8: A start_i sampled during a burst, including on its last beat, ends that burst. The next cycle is beat 0 of the new burst.
- R9: Changes on bl_code_i, btype_i and start_col_i while start_i is low do not affect a running burst.
- R10: The cycle after a last beat with no new strobe has valid_o = 0, and valid_o stays 0 until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Burst start strobe (read or write) |
| start_col_i | input | 9 | Starting column address |
| bl_code_i | input | 3 | Burst length code |
| btype_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | Beat present |
| last_o | output | 1 | Final beat of the burst |

## Verification
Two things can happen in the same cycle: a burst reaching its final beat and a new strobe arriving. That strobe can also come in the middle of a burst. The bench forces a strobe on the exact cycle where last_o is high, and its random phase fires strobes on arbitrary beats of running bursts. After each such strobe, a cycle-level model in the bench expects beat 0 of the new burst with no idle cycle and no leftover beat from the old one, then compares valid_o, last_o and col_o on every cycle.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

   typedef enum logic {
      ORD_SEQ = 1'b0,
      ORD_ITL = 1'b1
   } order_e;

   localparam int unsigned LEN_CODES = 4;

endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode #(
   parameter int unsigned CODE_W = 3,
   parameter int unsigned OFF_W  = 3
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [OFF_W-1:0]  mask_o
);

   localparam int unsigned NUM_LEN = OFF_W + 1;

   logic [NUM_LEN-1:0][OFF_W-1:0] mask_tab;
   logic [NUM_LEN-1:0]            hit;

   generate
      if (CODE_W < $clog2(NUM_LEN)) begin : g_bad_code
         $error("bcg_len_decode: CODE_W too narrow for OFF_W");
      end
      for (genvar i = 0; i < NUM_LEN; i++) begin : g_len
         assign mask_tab[i] = OFF_W'((1 << i) - 1);
         assign hit[i]      = (code_i == CODE_W'(i));
      end
   endgenerate

   always_comb begin
      mask_o = '0;
      for (int i = 0; i < NUM_LEN; i++) begin
         if (hit[i]) mask_o = mask_tab[i];
      end
   end

endmodule

// File: rtl/bcg_beat_ctr.sv
module bcg_beat_ctr #(
   parameter int unsigned OFF_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [OFF_W-1:0] mask_i,
   output logic [OFF_W-1:0] cnt_o,
   output logic [OFF_W-1:0] mask_o,
   output logic             active_o,
   output logic             last_o
);

   logic [OFF_W-1:0] cnt_q;
   logic [OFF_W-1:0] mask_q;
   logic             act_q;
   logic             at_end;

   assign at_end = (cnt_q == mask_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         mask_q <= '0;
         act_q  <= 1'b0;
      end else if (load_i) begin
         cnt_q  <= '0;
         mask_q <= mask_i;
         act_q  <= 1'b1;
      end else if (act_q) begin
         if (at_end) begin
            act_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign cnt_o    = cnt_q;
   assign mask_o   = mask_q;
   assign active_o = act_q;
   assign last_o   = act_q & at_end;

endmodule

// File: rtl/bcg_order.sv
module bcg_order #(
   parameter int unsigned OFF_W     = 3,
   parameter bit          ITL_EN    = 1'b1
) (
   input  logic             itl_i,
   input  logic [OFF_W-1:0] off_i,
   input  logic [OFF_W-1:0] cnt_i,
   input  logic [OFF_W-1:0] mask_i,
   output logic [OFF_W-1:0] lo_o
);

   logic [OFF_W-1:0] seq_lo;
   logic [OFF_W-1:0] itl_lo;

   assign seq_lo = (off_i + cnt_i) & mask_i;

   generate
      if (ITL_EN) begin : g_itl
         assign itl_lo = (off_i ^ cnt_i) & mask_i;
         assign lo_o   = itl_i ? itl_lo : seq_lo;
      end else begin : g_seq_only
         assign itl_lo = '0;
         assign lo_o   = seq_lo;
      end
   endgenerate

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
   parameter int unsigned COL_W   = 9,
   parameter int unsigned OFF_W   = 3,
   parameter int unsigned CODE_W  = 3,
   parameter bit          ITL_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [COL_W-1:0]  start_col_i,
   input  logic [CODE_W-1:0] bl_code_i,
   input  logic              btype_i,
   output logic [COL_W-1:0]  col_o,
   output logic              valid_o,
   output logic              last_o
);

   import bcg_pkg::*;

   localparam int unsigned HI_W = COL_W - OFF_W;

   generate
      if (COL_W <= OFF_W) begin : g_bad_width
         $error("burst_col_gen: COL_W must exceed OFF_W");
      end
   endgenerate

   logic [COL_W-1:0] base_q;
   order_e           ord_q;
   logic [OFF_W-1:0] new_mask;
   logic [OFF_W-1:0] cnt;
   logic [OFF_W-1:0] mask;
   logic [OFF_W-1:0] lo;
   logic [OFF_W-1:0] off;
   logic             active;
   logic             last;

   bcg_len_decode #(.CODE_W(CODE_W), .OFF_W(OFF_W)) len_dec_i (
      .code_i (bl_code_i),
      .mask_o (new_mask)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         ord_q  <= ORD_SEQ;
      end else if (start_i) begin
         base_q <= start_col_i;
         ord_q  <= order_e'(btype_i);
      end
   end

   bcg_beat_ctr #(.OFF_W(OFF_W)) ctr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (start_i),
      .mask_i   (new_mask),
      .cnt_o    (cnt),
      .mask_o   (mask),
      .active_o (active),
      .last_o   (last)
   );

   assign off = base_q[OFF_W-1:0] & mask;

   bcg_order #(.OFF_W(OFF_W), .ITL_EN(ITL_EN)) order_i (
      .itl_i  (ord_q == ORD_ITL),
      .off_i  (off),
      .cnt_i  (cnt),
      .mask_i (mask),
      .lo_o   (lo)
   );

   logic [HI_W-1:0] hi;
   assign hi = base_q[COL_W-1:OFF_W];

   assign col_o   = {hi, (base_q[OFF_W-1:0] & ~mask) | lo};
   assign valid_o = active;
   assign last_o  = last;

endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
   parameter int unsigned COL_W  = 9,
   parameter int unsigned OFF_W  = 3,
   parameter int unsigned CODE_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [COL_W-1:0]  start_col_i,
   input logic [CODE_W-1:0] bl_code_i,
   input logic [COL_W-1:0]  col_o,
   input logic              valid_o,
   input logic              last_o
);

   p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (valid_o && col_o == $past(start_col_i)));

   p_single_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && bl_code_i == '0) |=> last_o);

   p_block_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && $past(valid_o) && !$past(start_i))
      |-> (col_o[COL_W-1:OFF_W] == $past(col_o[COL_W-1:OFF_W])));

   p_last_in_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);

   p_idle_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !start_i) |=> !valid_o);

   p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_o && !start_i) |=> !valid_o);

endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W), .OFF_W(OFF_W), .CODE_W(CODE_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .start_col_i (start_col_i),
   .bl_code_i   (bl_code_i),
   .col_o       (col_o),
   .valid_o     (valid_o),
   .last_o      (last_o)
);

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int RAND_CYCLES = 4000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [8:0] start_col_i = '0;
   logic [2:0] bl_code_i = '0;
   logic       btype_i = 1'b0;
   logic [8:0] col_o;
   logic       valid_o;
   logic       last_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // bench model
   bit       m_act = 1'b0;
   int       m_n = 0;
   int       m_len = 1;
   logic [8:0] m_col = '0;
   bit       m_itl = 1'b0;
   bit       m_restart = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_col_gen dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .start_col_i (start_col_i),
      .bl_code_i   (bl_code_i),
      .btype_i     (btype_i),
      .col_o       (col_o),
      .valid_o     (valid_o),
      .last_o      (last_o)
   );

   function automatic int len_of(input logic [2:0] code);
      case (code)
         3'd1: return 2;
         3'd2: return 4;
         3'd3: return 8;
         default: return 1;
      endcase
   endfunction

   function automatic logic [8:0] exp_col(input logic [8:0] s, input int len,
                                         input bit itl, input int n);
      logic [8:0] msk;
      logic [8:0] off;
      logic [8:0] lo;
      msk = 9'(len - 1);
      off = s & msk;
      if (itl) lo = (off ^ 9'(n)) & msk;
      else     lo = (off + 9'(n)) & msk;
      return (s & ~msk) | lo;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // compare outputs with the model; called away from the clock edge
   task automatic compare();
      logic [8:0] ec;
      bit         el;
      check(valid_o == m_act, m_act ? "R3 valid during burst" : "R10 idle valid",
            int'(valid_o), int'(m_act));
      if (m_act) begin
         ec = exp_col(m_col, m_len, m_itl, m_n);
         el = (m_n == m_len - 1);
         if (m_n == 0)
            check(col_o == ec, m_restart ? "R8 restart col" : "R2 first col",
                  int'(col_o), int'(ec));
         else if (col_o[8:3] != ec[8:3])
            check(1'b0, "R4 block bits", int'(col_o), int'(ec));
         else
            check(col_o == ec, m_itl ? "R6 interleaved col" : "R5 sequential col",
                  int'(col_o), int'(ec));
         check(last_o == el, "R7 last flag", int'(last_o), int'(el));
      end else begin
         check(last_o == 1'b0, "R7 last while idle", int'(last_o), 0);
      end
   endtask

   // one cycle: compare, drive, clock, update model
   task automatic cycle(input bit st, input logic [8:0] c, input logic [2:0] code,
                        input bit itl);
      compare();
      start_i     = st;
      start_col_i = c;
      bl_code_i   = code;
      btype_i     = itl;
      @(posedge clk);
      if (st) begin
         m_restart = m_act && (m_n != m_len - 1);
         m_act = 1'b1;
         m_n   = 0;
         m_len = len_of(code);
         m_col = c;
         m_itl = itl;
      end else if (m_act) begin
         if (m_n == m_len - 1) m_act = 1'b0;
         else m_n++;
      end
      @(negedge clk);
   endtask

   task automatic noise();
      cycle(1'b0, 9'($urandom), 3'($urandom), 1'($urandom));
   endtask

   task automatic run_burst(input logic [8:0] c, input logic [2:0] code, input bit itl);
      cycle(1'b1, c, code, itl);
      while (m_act) noise();   // R9: config scrambled mid-burst
   endtask

   initial begin
      void'($urandom(32'd4242));
      start_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
      // R1: outputs low in reset
      check(valid_o == 1'b0 && last_o == 1'b0, "R1 reset state",
            int'({valid_o, last_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      cycle(1'b0, '0, '0, 1'b0);   // R1 after release

      // R5/R4: sequential length 8 wrapping at block boundary
      run_burst(9'h1FD, 3'd3, 1'b0);
      // R6: interleaved length 8
      run_burst(9'h0B5, 3'd3, 1'b1);
      // R6: interleaved length 4 offset 3
      run_burst(9'h043, 3'd2, 1'b1);
      // R5: sequential length 2 odd start
      run_burst(9'h101, 3'd1, 1'b0);
      // R7: length 1 single beat
      run_burst(9'h0AA, 3'd0, 1'b0);
      // R3: reserved code behaves as length 1
      run_burst(9'h155, 3'd6, 1'b1);
      noise();
      // R8: restart on the last beat (cycle where last_o is high)
      cycle(1'b1, 9'h03E, 3'd2, 1'b0);
      noise(); noise(); noise();
      cycle(1'b1, 9'h1C7, 3'd3, 1'b1);
      // R8: interrupt mid-burst
      noise(); noise();
      cycle(1'b1, 9'h012, 3'd3, 1'b0);
      while (m_act) noise();
      noise(); noise();   // R10 idle holds

      // random phase
      for (int i = 0; i < RAND_CYCLES; i++) begin
         int r;
         r = int'($urandom % 100);
         if (m_act) cycle(r < 12, 9'($urandom), 3'($urandom), 1'($urandom));
         else       cycle(r < 55, 9'($urandom), 3'($urandom), 1'($urandom));
      end
      while (m_act) noise();
      noise();

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule